// File: doc/BRIEF.md
# Strided Tile Copy Engine with Completion Flags

This block moves two-dimensional tiles between a large backing memory and a local scratchpad while the issuing core keeps running. The core hands over a descriptor on a valid/ready command stream. The descriptor holds a source base, a destination base, an inner length and stride, an outer length and stride, a completion flag index, a direction bit and a remote bit. The descriptor waits in a small queue. The engine then walks the source with the two strides, inner dimension first, and writes the destination as one dense run. A single descriptor can therefore cut a sub-block out of a larger array.

When the last element of a descriptor has been written, the engine sets the chosen bit in a bank of completion flags. The core can read that bank, clear a bit, or hold its issue on a bit until the data has landed. A descriptor aimed at another chip uses the same format but may only push data outward, through a valid/ready remote port. A remote descriptor that asks for a read is dropped and reported on an error pulse.

Both memories sit behind request/grant ports. A request, with its address, write enable and write data, stays stable until it is granted. Read data returns in the cycle after the grant. On the command stream, a descriptor is taken on any cycle where `cmd_valid` and `cmd_ready` are both high. The source may hold `cmd_valid` high for as long as it likes, and `cmd_ready` drops only when the queue is full. On the remote port, a beat moves when `rm_valid` and `rm_ready` are both high. Until then the engine holds `rm_valid`, `rm_addr` and `rm_data` steady.

Top module: `strided_dma`

## Requirements
- R1: A descriptor is accepted on a rising clock edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low only while the queue holds QDEPTH descriptors. The descriptor being executed does not occupy the queue, so a stalled engine accepts QDEPTH+1 descriptors.
- R2: Length fields hold the count minus one. Element (i, o), with i in 0..inner_len and o in 0..outer_len, is read from source address src + o·outer_stride + i·inner_stride. It is written to destination address dst + o·(inner_len+1) + i. i advances fastest. All address arithmetic wraps modulo 2^AW.
- R3: With `cmd_push`=0, data moves from the backing memory to the scratchpad. With `cmd_push`=1 and `cmd_remote`=0, data moves from the scratchpad to the backing memory. With `cmd_push`=1 and `cmd_remote`=1, data moves from the scratchpad to the remote port.
- R4: A descriptor with `cmd_remote`=1 and `cmd_push`=0 is discarded. It makes no memory or remote access, sets no flag, and raises `err_pulse` for exactly one cycle.
- R5: When the last write of a descriptor is granted, bit `cmd_flag` of `flags` reads 1 from the next cycle on.
- R6: Descriptors finish in the order they were accepted.
- R7: A set flag stays set until `flag_clr_valid` names it. The clear takes effect on the next cycle. When a completion and a clear target the same flag on the same edge, the completion wins.
- R8: `stall` is high exactly while `wait_valid` is high and flag `wait_idx` is clear. There is no cycle of delay.
- R9: A memory request keeps its address, write enable and write data until it is granted. Only one of the backing, scratchpad and remote ports is active at a time.
- R10: While reset is held, and right after it, all flags are clear, `cmd_ready` is high, and there is no request or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cmd_valid | input | 1 | Descriptor offered |
| cmd_ready | output | 1 | Queue has room |
| cmd_src | input | AW | Source base address |
| cmd_dst | input | AW | Destination base address |
| cmd_inner_len | input | CW | Inner count minus one |
| cmd_inner_stride | input | AW | Source step between inner elements |
| cmd_outer_len | input | CW | Outer count minus one |
| cmd_outer_stride | input | AW | Source step between rows |
| cmd_flag | input | FW | Completion flag index |
| cmd_push | input | 1 | 0: backing to scratchpad, 1: scratchpad outward |
| cmd_remote | input | 1 | Destination is the remote port |
| bk_req | output | 1 | Backing memory request |
| bk_we | output | 1 | Backing memory write enable |
| bk_addr | output | AW | Backing memory address |
| bk_wdata | output | DW | Backing memory write data |
| bk_gnt | input | 1 | Backing memory grant |
| bk_rdata | input | DW | Backing read data, cycle after grant |
| sp_req | output | 1 | Scratchpad request |
| sp_we | output | 1 | Scratchpad write enable |
| sp_addr | output | AW | Scratchpad address |
| sp_wdata | output | DW | Scratchpad write data |
| sp_gnt | input | 1 | Scratchpad grant |
| sp_rdata | input | DW | Scratchpad read data, cycle after grant |
| rm_valid | output | 1 | Remote push beat valid |
| rm_ready | input | 1 | Remote link accepts beat |
| rm_addr | output | AW | Remote destination address |
| rm_data | output | DW | Remote push data |
| flag_clr_valid | input | 1 | Clear one flag |
| flag_clr_idx | input | FW | Flag to clear |
| wait_valid | input | 1 | Core is waiting on a flag |
| wait_idx | input | FW | Flag being waited on |
| stall | output | 1 | Hold core issue |
| flags | output | NFLAG | Completion flag bank |
| err_pulse | output | 1 | Rejected remote read |

## Verification
Each kind of wrong internal state shows up at the ports in its own way:

- **Address walker:** a counter slip in the walker puts data at a wrong scratchpad or backing address. The scratchpad or backing image then differs from the model as soon as that descriptor's flag rises.
- **Completion handling:** a lost or misrouted completion leaves `stall` high until the run's timeout. Completion out of order shows as a later flag rising before an earlier one.
- **Queue bookkeeping:** a wrong occupancy count changes how many descriptors a stalled engine takes in within a fixed window.
- **Rejection logic:** a broken reject path shows up within a few cycles, as a missing error pulse, a stray memory grant or a flag that should have stayed clear.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_LATCH = 2'd2,
    ST_WRITE = 2'd3
  } eng_state_e;

  // A remote destination may only be written; a remote read is refused.
  function automatic logic refuse_desc(input logic push, input logic remote);
    return remote && !push;
  endfunction

endpackage

// File: rtl/sdma_cmd_queue.sv
module sdma_cmd_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic         empty,
  output logic [W-1:0] head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [NW-1:0] used;
  logic          take;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign in_ready = (used != NW'(DEPTH));
  assign take     = in_valid && in_ready;
  assign empty    = (used == '0);
  assign head     = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (take) slots[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (take) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({take, pop})
        2'b10:   used <= used + NW'(1);
        2'b01:   used <= used - NW'(1);
        default: used <= used;
      endcase
    end
  end
endmodule

// File: rtl/sdma_addr_walk.sv
module sdma_addr_walk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] in_len,
  input  logic [AW-1:0] in_stride,
  input  logic [CW-1:0] out_len,
  input  logic [AW-1:0] out_stride,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          last
);
  logic [CW-1:0] i_q, o_q, in_len_q, out_len_q;
  logic [AW-1:0] row_q, in_stride_q, out_stride_q, src_q, dst_q;
  logic          row_end;
  logic [AW-1:0] next_row;

  assign row_end  = (i_q == in_len_q);
  assign last     = row_end && (o_q == out_len_q);
  assign next_row = row_q + out_stride_q;
  assign src_addr = src_q;
  assign dst_addr = dst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_q <= '0; o_q <= '0; in_len_q <= '0; out_len_q <= '0;
      row_q <= '0; in_stride_q <= '0; out_stride_q <= '0;
      src_q <= '0; dst_q <= '0;
    end else if (load) begin
      i_q          <= '0;
      o_q          <= '0;
      in_len_q     <= in_len;
      out_len_q    <= out_len;
      in_stride_q  <= in_stride;
      out_stride_q <= out_stride;
      row_q        <= src_base;
      src_q        <= src_base;
      dst_q        <= dst_base;
    end else if (step) begin
      dst_q <= dst_q + AW'(1);
      if (row_end) begin
        i_q   <= '0;
        o_q   <= o_q + CW'(1);
        row_q <= next_row;
        src_q <= next_row;
      end else begin
        i_q   <= i_q + CW'(1);
        src_q <= src_q + in_stride_q;
      end
    end
  end
endmodule

// File: rtl/sdma_sync_flags.sv
module sdma_sync_flags #(
  parameter int NF = 16,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [FW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [FW-1:0] clr_idx,
  input  logic          wait_en,
  input  logic [FW-1:0] wait_idx,
  output logic [NF-1:0] bank,
  output logic          hold
);
  for (genvar k = 0; k < NF; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                bank[k] <= 1'b0;
      else if (set_en && (set_idx == FW'(k)))    bank[k] <= 1'b1;
      else if (clr_en && (clr_idx == FW'(k)))    bank[k] <= 1'b0;
    end
  end

  assign hold = wait_en && !bank[wait_idx];
endmodule

// File: rtl/strided_dma.sv
module strided_dma
  import sdma_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int CW     = 8,
  parameter int NFLAG  = 16,
  parameter int QDEPTH = 4,
  localparam int FW    = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [AW-1:0]    cmd_src,
  input  logic [AW-1:0]    cmd_dst,
  input  logic [CW-1:0]    cmd_inner_len,
  input  logic [AW-1:0]    cmd_inner_stride,
  input  logic [CW-1:0]    cmd_outer_len,
  input  logic [AW-1:0]    cmd_outer_stride,
  input  logic [FW-1:0]    cmd_flag,
  input  logic             cmd_push,
  input  logic             cmd_remote,
  output logic             bk_req,
  output logic             bk_we,
  output logic [AW-1:0]    bk_addr,
  output logic [DW-1:0]    bk_wdata,
  input  logic             bk_gnt,
  input  logic [DW-1:0]    bk_rdata,
  output logic             sp_req,
  output logic             sp_we,
  output logic [AW-1:0]    sp_addr,
  output logic [DW-1:0]    sp_wdata,
  input  logic             sp_gnt,
  input  logic [DW-1:0]    sp_rdata,
  output logic             rm_valid,
  input  logic             rm_ready,
  output logic [AW-1:0]    rm_addr,
  output logic [DW-1:0]    rm_data,
  input  logic             flag_clr_valid,
  input  logic [FW-1:0]    flag_clr_idx,
  input  logic             wait_valid,
  input  logic [FW-1:0]    wait_idx,
  output logic             stall,
  output logic [NFLAG-1:0] flags,
  output logic             err_pulse
);
  localparam int DESC_W = 4*AW + 2*CW + FW + 2;

  // queue side
  logic [DESC_W-1:0] q_in, q_head;
  logic              q_empty, q_pop;
  logic [AW-1:0]     h_src, h_dst, h_istr, h_ostr;
  logic [CW-1:0]     h_ilen, h_olen;
  logic [FW-1:0]     h_flag;
  logic              h_push, h_remote, h_refuse;

  assign q_in = {cmd_src, cmd_dst, cmd_inner_len, cmd_inner_stride,
                 cmd_outer_len, cmd_outer_stride, cmd_flag, cmd_push, cmd_remote};

  sdma_cmd_queue #(.W(DESC_W), .DEPTH(QDEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (cmd_valid),
    .in_ready (cmd_ready),
    .in_data  (q_in),
    .pop      (q_pop),
    .empty    (q_empty),
    .head     (q_head)
  );

  assign {h_src, h_dst, h_ilen, h_istr, h_olen, h_ostr, h_flag, h_push, h_remote} = q_head;
  assign h_refuse = refuse_desc(h_push, h_remote);

  // engine state
  eng_state_e     st_q;
  logic           cur_push, cur_remote;
  logic [FW-1:0]  cur_flag;
  logic [DW-1:0]  data_q;
  logic           err_q;
  logic           in_read, in_write;
  logic           rd_gnt, wr_done, walk_last, walk_load, walk_step;
  logic [DW-1:0]  rd_data;
  logic [AW-1:0]  src_addr, dst_addr;
  logic           cpl_set;
  logic [FW-1:0]  cpl_idx;

  assign q_pop     = (st_q == ST_IDLE) && !q_empty;
  assign walk_load = q_pop && !h_refuse;
  assign in_read   = (st_q == ST_READ);
  assign in_write  = (st_q == ST_WRITE);

  sdma_addr_walk #(.AW(AW), .CW(CW)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (walk_load),
    .step       (walk_step),
    .src_base   (h_src),
    .dst_base   (h_dst),
    .in_len     (h_ilen),
    .in_stride  (h_istr),
    .out_len    (h_olen),
    .out_stride (h_ostr),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .last       (walk_last)
  );

  // port steering: source is scratchpad when pushing, else backing
  assign bk_req   = (in_read && !cur_push) || (in_write && cur_push && !cur_remote);
  assign bk_we    = in_write;
  assign bk_addr  = in_read ? src_addr : dst_addr;
  assign bk_wdata = data_q;

  assign sp_req   = (in_read && cur_push) || (in_write && !cur_push);
  assign sp_we    = in_write;
  assign sp_addr  = in_read ? src_addr : dst_addr;
  assign sp_wdata = data_q;

  assign rm_valid = in_write && cur_push && cur_remote;
  assign rm_addr  = dst_addr;
  assign rm_data  = data_q;

  assign rd_gnt  = cur_push ? sp_gnt   : bk_gnt;
  assign rd_data = cur_push ? sp_rdata : bk_rdata;

  assign wr_done   = (bk_req && bk_gnt && in_write) || (sp_req && sp_gnt && in_write) ||
                     (rm_valid && rm_ready);
  assign walk_step = wr_done && !walk_last;
  assign cpl_set   = wr_done && walk_last;
  assign cpl_idx   = cur_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cur_push   <= 1'b0;
      cur_remote <= 1'b0;
      cur_flag   <= '0;
      data_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= q_pop && h_refuse;
      unique case (st_q)
        ST_IDLE: begin
          if (walk_load) begin
            st_q       <= ST_READ;
            cur_push   <= h_push;
            cur_remote <= h_remote;
            cur_flag   <= h_flag;
          end
        end
        ST_READ:  if (rd_gnt) st_q <= ST_LATCH;
        ST_LATCH: begin
          data_q <= rd_data;
          st_q   <= ST_WRITE;
        end
        ST_WRITE: if (wr_done) st_q <= walk_last ? ST_IDLE : ST_READ;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign err_pulse = err_q;

  sdma_sync_flags #(.NF(NFLAG), .FW(FW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (cpl_set),
    .set_idx  (cpl_idx),
    .clr_en   (flag_clr_valid),
    .clr_idx  (flag_clr_idx),
    .wait_en  (wait_valid),
    .wait_idx (wait_idx),
    .bank     (flags),
    .hold     (stall)
  );
endmodule

// File: rtl/strided_dma_chk.sv
module strided_dma_chk #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int NFLAG = 16,
  localparam int FW   = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bk_req,
  input logic             bk_we,
  input logic [AW-1:0]    bk_addr,
  input logic [DW-1:0]    bk_wdata,
  input logic             bk_gnt,
  input logic             sp_req,
  input logic             sp_we,
  input logic [AW-1:0]    sp_addr,
  input logic [DW-1:0]    sp_wdata,
  input logic             sp_gnt,
  input logic             rm_valid,
  input logic             rm_ready,
  input logic [AW-1:0]    rm_addr,
  input logic [DW-1:0]    rm_data,
  input logic             flag_clr_valid,
  input logic [FW-1:0]    flag_clr_idx,
  input logic [NFLAG-1:0] flags,
  input logic             err_pulse,
  input logic             cpl_set,
  input logic [FW-1:0]    cpl_idx
);
  assert_one_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bk_req, sp_req, rm_valid}));

  assert_bk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_req && !bk_gnt) |=> (bk_req && $stable(bk_addr) && $stable(bk_we) && $stable(bk_wdata)));

  assert_sp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_req && !sp_gnt) |=> (sp_req && $stable(sp_addr) && $stable(sp_we) && $stable(sp_wdata)));

  assert_rm_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_valid && !rm_ready) |=> (rm_valid && $stable(rm_addr) && $stable(rm_data)));

  assert_reject_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> ((flags & ~$past(flags)) == '0));

  assert_reject_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !(bk_req || sp_req || rm_valid));

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[k] && !(flag_clr_valid && flag_clr_idx == FW'(k))) |=> flags[k]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_set && cpl_idx == FW'(k)) |=> flags[k]);
  end
endmodule

bind strided_dma strided_dma_chk #(.AW(AW), .DW(DW), .NFLAG(NFLAG)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bk_req         (bk_req),
  .bk_we          (bk_we),
  .bk_addr        (bk_addr),
  .bk_wdata       (bk_wdata),
  .bk_gnt         (bk_gnt),
  .sp_req         (sp_req),
  .sp_we          (sp_we),
  .sp_addr        (sp_addr),
  .sp_wdata       (sp_wdata),
  .sp_gnt         (sp_gnt),
  .rm_valid       (rm_valid),
  .rm_ready       (rm_ready),
  .rm_addr        (rm_addr),
  .rm_data        (rm_data),
  .flag_clr_valid (flag_clr_valid),
  .flag_clr_idx   (flag_clr_idx),
  .flags          (flags),
  .err_pulse      (err_pulse),
  .cpl_set        (cpl_set),
  .cpl_idx        (cpl_idx)
);

// File: tb/test_strided_dma.sv
`timescale 1ns/1ps
module test_strided_dma;
  localparam int AW = 8, DW = 32, CW = 4, NFLAG = 8, QDEPTH = 4, FW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready;
  logic [AW-1:0] cmd_src = 0, cmd_dst = 0, cmd_inner_stride = 0, cmd_outer_stride = 0;
  logic [CW-1:0] cmd_inner_len = 0, cmd_outer_len = 0;
  logic [FW-1:0] cmd_flag = 0;
  logic cmd_push = 0, cmd_remote = 0;
  logic bk_req, bk_we, bk_gnt, sp_req, sp_we, sp_gnt, rm_valid, rm_ready;
  logic [AW-1:0] bk_addr, sp_addr, rm_addr;
  logic [DW-1:0] bk_wdata, sp_wdata, rm_data;
  logic [DW-1:0] bk_rdata = 0, sp_rdata = 0;
  logic flag_clr_valid = 0, wait_valid = 0, stall, err_pulse;
  logic [FW-1:0] flag_clr_idx = 0, wait_idx = 0;
  logic [NFLAG-1:0] flags;

  strided_dma #(.AW(AW), .DW(DW), .CW(CW), .NFLAG(NFLAG), .QDEPTH(QDEPTH)) i_strided_dma (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_inner_len(cmd_inner_len),
    .cmd_inner_stride(cmd_inner_stride), .cmd_outer_len(cmd_outer_len),
    .cmd_outer_stride(cmd_outer_stride), .cmd_flag(cmd_flag), .cmd_push(cmd_push),
    .cmd_remote(cmd_remote), .bk_req(bk_req), .bk_we(bk_we), .bk_addr(bk_addr),
    .bk_wdata(bk_wdata), .bk_gnt(bk_gnt), .bk_rdata(bk_rdata), .sp_req(sp_req),
    .sp_we(sp_we), .sp_addr(sp_addr), .sp_wdata(sp_wdata), .sp_gnt(sp_gnt),
    .sp_rdata(sp_rdata), .rm_valid(rm_valid), .rm_ready(rm_ready), .rm_addr(rm_addr),
    .rm_data(rm_data), .flag_clr_valid(flag_clr_valid), .flag_clr_idx(flag_clr_idx),
    .wait_valid(wait_valid), .wait_idx(wait_idx), .stall(stall), .flags(flags),
    .err_pulse(err_pulse)
  );

  // memory models with a grant pattern that withholds every fourth cycle
  logic [DW-1:0] bk_mem [256];
  logic [DW-1:0] sp_mem [256];
  logic [DW-1:0] mdl_bk [256];
  logic [DW-1:0] mdl_sp [256];
  logic [1:0] gpat = 0;
  logic block = 0;
  assign bk_gnt   = bk_req && !block && (gpat != 2'd3);
  assign sp_gnt   = sp_req && !block && (gpat != 2'd1);
  assign rm_ready = !block && (gpat != 2'd2);

  int grants = 0, errs = 0, rbeats = 0;
  logic [AW-1:0] r_addr [16];
  logic [DW-1:0] r_data [16];

  always @(posedge clk) begin
    gpat <= gpat + 2'd1;
    if (bk_req && bk_gnt) begin
      if (bk_we) bk_mem[bk_addr] <= bk_wdata; else bk_rdata <= bk_mem[bk_addr];
    end
    if (sp_req && sp_gnt) begin
      if (sp_we) sp_mem[sp_addr] <= sp_wdata; else sp_rdata <= sp_mem[sp_addr];
    end
    if ((bk_req && bk_gnt) || (sp_req && sp_gnt) || (rm_valid && rm_ready)) grants <= grants + 1;
    if (err_pulse) errs <= errs + 1;
    if (rm_valid && rm_ready && rbeats < 16) begin
      r_addr[rbeats] <= rm_addr;
      r_data[rbeats] <= rm_data;
      rbeats <= rbeats + 1;
    end
  end

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0] src; logic [7:0] dst; logic [3:0] ilen; logic [7:0] istr;
    logic [3:0] olen; logic [7:0] ostr; logic [2:0] flag; logic push;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'd10,  8'd0,   4'd3, 8'd1, 4'd1, 8'd16, 3'd0, 1'b0},
    '{8'd40,  8'd20,  4'd2, 8'd5, 4'd2, 8'd2,  3'd1, 1'b0},
    '{8'd0,   8'd200, 4'd7, 8'd1, 4'd0, 8'd0,  3'd2, 1'b1},
    '{8'd99,  8'd60,  4'd0, 8'd0, 4'd0, 8'd0,  3'd3, 1'b0},
    '{8'd5,   8'd220, 4'd3, 8'd0, 4'd1, 8'd1,  3'd4, 1'b1}
  };

  task automatic issue(input logic [7:0] s, input logic [7:0] d, input logic [3:0] il,
                       input logic [7:0] is, input logic [3:0] ol, input logic [7:0] os,
                       input logic [2:0] f, input logic p, input logic r);
    @(negedge clk);
    cmd_src = s; cmd_dst = d; cmd_inner_len = il; cmd_inner_stride = is;
    cmd_outer_len = ol; cmd_outer_stride = os; cmd_flag = f; cmd_push = p; cmd_remote = r;
    cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  // waits through the stall pin; returns cycles spent
  task automatic wait_on(input logic [2:0] f, output int n);
    @(negedge clk);
    wait_valid = 1; wait_idx = f;
    n = 0;
    #1;
    while (stall && n < 3000) begin @(negedge clk); #1; n++; end
    wait_valid = 0;
  endtask

  task automatic clear_flag(input logic [2:0] f);
    @(negedge clk);
    flag_clr_valid = 1; flag_clr_idx = f;
    @(negedge clk);
    flag_clr_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, mism, t0, t1, ones, g0, e0;
    for (int a = 0; a < 256; a++) begin
      bk_mem[a] = 32'h1000_0000 + a * 3;
      sp_mem[a] = 32'h5500_0000 + a;
      mdl_bk[a] = bk_mem[a];
      mdl_sp[a] = sp_mem[a];
    end

    // reset state, R10
    repeat (3) @(negedge clk);
    check(cmd_ready && flags == 0 && !err_pulse && !bk_req && !sp_req && !rm_valid,
          "R10", "idle under reset", {flags, cmd_ready}, 1);
    rst_n = 1;
    @(negedge clk);
    check(cmd_ready && flags == 0 && !err_pulse && !bk_req && !sp_req && !rm_valid,
          "R10", "idle after reset", {flags, cmd_ready}, 1);

    // vector table: R2, R3, R5
    for (int v = 0; v < NV; v++) begin
      vec_t x;
      logic [7:0] sa, da;
      x = VECS[v];
      issue(x.src, x.dst, x.ilen, x.istr, x.olen, x.ostr, x.flag, x.push, 1'b0);
      wait_on(x.flag, n);
      check(flags[x.flag] == 1'b1, "R5", $sformatf("vec%0d flag", v), flags, 1 << x.flag);
      mism = 0;
      for (int o = 0; o <= int'(x.olen); o++)
        for (int i = 0; i <= int'(x.ilen); i++) begin
          sa = x.src + 8'(o) * x.ostr + 8'(i) * x.istr;
          da = x.dst + 8'(o) * (8'(x.ilen) + 8'd1) + 8'(i);
          if (x.push) mdl_bk[da] = mdl_sp[sa]; else mdl_sp[da] = mdl_bk[sa];
        end
      for (int a = 0; a < 256; a++) begin
        if (x.push ? (bk_mem[a] !== mdl_bk[a]) : (sp_mem[a] !== mdl_sp[a])) begin
          if (mism == 0)
            $display("FAIL R2 vec%0d addr %0d: actual=%0h expected=%0h", v, a,
                     x.push ? bk_mem[a] : sp_mem[a], x.push ? mdl_bk[a] : mdl_sp[a]);
          mism++;
        end
      end
      total++;
      if (mism != 0) bad++;
    end

    // wait pin, R8
    @(negedge clk);
    wait_valid = 1; wait_idx = 3'd5; #1;
    check(stall == 1'b1, "R8", "stall on clear flag", stall, 1);
    wait_valid = 0;
    issue(8'd120, 8'd100, 4'd1, 8'd1, 4'd0, 8'd0, 3'd5, 1'b0, 1'b0);
    wait_on(3'd5, n);
    check(n < 3000 && !stall, "R8", "stall released by completion", n, 0);

    // remote push, R3
    issue(8'd0, 8'd77, 4'd3, 8'd2, 4'd0, 8'd0, 3'd6, 1'b1, 1'b1);
    wait_on(3'd6, n);
    check(rbeats == 4, "R3", "remote beat count", rbeats, 4);
    mism = 0;
    for (int i = 0; i < 4; i++)
      if (r_addr[i] !== 8'(77 + i) || r_data[i] !== mdl_sp[2 * i]) mism++;
    check(mism == 0, "R3", "remote beats addr/data", r_data[0], mdl_sp[0]);

    // remote read refused, R4
    g0 = grants; e0 = errs;
    issue(8'd1, 8'd2, 4'd2, 8'd1, 4'd0, 8'd0, 3'd7, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check(errs - e0 == 1, "R4", "error pulses", errs - e0, 1);
    check(flags[7] == 1'b0, "R4", "flag left clear", flags[7], 0);
    check(grants == g0, "R4", "no access", grants - g0, 0);

    // clear, R7
    clear_flag(3'd0);
    check(flags[0] == 1'b0 && flags[1] == 1'b1, "R7", "clear one, others stay", flags[1:0], 2);
    for (int f = 1; f < NFLAG; f++) clear_flag(3'(f));
    check(flags == 0, "R7", "all cleared", flags, 0);

    // queue depth and order, R1 and R6
    block = 1;
    issue(8'd0, 8'd128, 4'd7, 8'd1, 4'd1, 8'd8, 3'd0, 1'b0, 1'b0);
    issue(8'd50, 8'd160, 4'd0, 8'd0, 4'd0, 8'd0, 3'd1, 1'b0, 1'b0);
    @(negedge clk);
    cmd_src = 8'd51; cmd_dst = 8'd161; cmd_inner_len = 0; cmd_outer_len = 0;
    cmd_flag = 3'd2; cmd_push = 0; cmd_remote = 0; cmd_valid = 1;
    n = 0;
    repeat (20) begin
      if (cmd_ready) n++;
      @(negedge clk);
    end
    cmd_valid = 0;
    check(n == QDEPTH - 1, "R1", "descriptors taken while stalled", n, QDEPTH - 1);
    block = 0;
    t0 = -1; t1 = -1;
    for (int c = 0; c < 3000 && !(flags[0] && flags[1] && flags[2]); c++) begin
      @(negedge clk);
      if (flags[0] && t0 < 0) t0 = c;
      if (flags[1] && t1 < 0) t1 = c;
    end
    check(t0 >= 0 && t1 > t0, "R6", "first descriptor finishes first", t1, t0);

    // completion beats a simultaneous clear, R7
    clear_flag(3'd3);
    @(negedge clk);
    flag_clr_valid = 1; flag_clr_idx = 3'd3;
    issue(8'd30, 8'd40, 4'd0, 8'd0, 4'd0, 8'd0, 3'd3, 1'b0, 1'b0);
    ones = 0;
    repeat (100) begin
      @(negedge clk);
      if (flags[3]) ones++;
    end
    flag_clr_valid = 0;
    check(ones == 1, "R7", "set wins over held clear", ones, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule